// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This block settles conditional branches for a small 32-bit processor. It has no flags register. A compare operation copies its two register operands unchanged into a pair of hidden holding registers. A later branch picks one of ten relations, signed or unsigned, through a 4-bit selector. The relation is tested between the held pair only when that branch runs. The unit then drives the next program counter, which is either the sequential address or a PC-relative target.

The branch side is combinational, so the next PC is available in the same cycle as the branch request. The compare side writes on the clock edge. When a compare and a branch arrive together, the branch sees the values stored before that edge. A selector outside the defined set, or an opcode that is not in branch format, raises an illegal flag. In that case the next PC stays at the faulting branch, so the exception logic can report the branch address. A parameter chooses how the relations are produced: one shared subtractor, or separate comparators.

Top module: `cbr_resolve_unit`

## Requirements
- R1: When cmp_valid_i is high at a rising clock edge, the holding registers take cmp_a_i and cmp_b_i unchanged. Otherwise they keep their value.
- R2: Reset clears both holding registers to zero. A branch issued before any compare therefore compares 0 with 0, so eq is taken and lt is not.
- R3: A branch is well formed only when opcode bits 15 and 14 are both 1. A valid request with any other pattern in those bits sets illegal_o.
- R4: The selector sits in opcode bits 13:10. Each code tests held A against held B: 0 A==B, 1 A!=B, 2 A<B signed, 3 A>B signed, 4 A<B unsigned, 5 A>B unsigned, 6 A>=B signed, 7 A<=B signed, 8 A>=B unsigned, 9 A<=B unsigned.
- R5: For a taken branch, next_pc_o is br_pc_i + 2 + D. D is opcode bits 9:0, sign-extended and multiplied by two, which gives a range of -1024 to +1022.
- R6: For a valid, legal, not-taken branch, next_pc_o is br_pc_i + 2 and taken_o is 0.
- R7: Selector codes 10 to 15 in a valid branch set illegal_o and clear taken_o, and next_pc_o equals br_pc_i.
- R8: When a compare and a branch arrive in the same cycle, the branch uses the values held before that edge. The new operands apply from the next cycle.
- R9: While br_valid_i is low, taken_o and illegal_o are 0 and next_pc_o is br_pc_i + 2.
- R10: Both settings of the comparator parameter SHARED_SUB give the same taken_o, illegal_o and next_pc_o for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid_i | input | 1 | Compare request; loads the holding registers |
| cmp_a_i | input | 32 | First compare operand |
| cmp_b_i | input | 32 | Second compare operand |
| br_valid_i | input | 1 | Branch request |
| br_opcode_i | input | 16 | Branch instruction word |
| br_pc_i | input | 32 | Address of the branch |
| next_pc_o | output | 32 | Resolved next program counter |
| taken_o | output | 1 | Branch condition holds |
| illegal_o | output | 1 | Bad selector or non-branch format |

## Verification
The bench builds two copies of the unit side by side. One uses the default shared-subtractor comparator (SHARED_SUB=1) and the other uses direct comparators (SHARED_SUB=0). Every check is applied to both copies, so any disagreement between the two variants shows up as a failure. Both keep the default widths of 32-bit data, a 16-bit opcode and a 10-bit offset. With these widths, sign-boundary operands such as 0x80000000 against 0x7FFFFFFF can be used, as can the extreme offsets +1022 and -1024.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   // Relation selector codes; the numeric order is decoded by the branch field.
   typedef enum logic [3:0] {
      CND_EQ  = 4'd0,
      CND_NE  = 4'd1,
      CND_SLT = 4'd2,
      CND_SGT = 4'd3,
      CND_ULT = 4'd4,
      CND_UGT = 4'd5,
      CND_SGE = 4'd6,
      CND_SLE = 4'd7,
      CND_UGE = 4'd8,
      CND_ULE = 4'd9
   } cond_e;

   localparam int unsigned NUM_COND = 10;

   // Primitive relations from which all ten conditions are formed.
   typedef struct packed {
      logic eq;
      logic slt;
      logic ult;
   } rel_t;

endpackage

// File: rtl/cbr_hold_regs.sv
module cbr_hold_regs #(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic [XLEN-1:0] a_q,
   output logic [XLEN-1:0] b_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (ld_i) begin
         a_q <= a_i;
         b_q <= b_i;
      end
   end

endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
   import cbr_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned SEL_W      = 4,
   parameter bit          SHARED_SUB = 1'b1
) (
   input  logic [XLEN-1:0]  a_i,
   input  logic [XLEN-1:0]  b_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             take_o,
   output logic             bad_sel_o
);

   localparam int unsigned MSB = XLEN - 1;

   rel_t rel;

   generate
      if (SHARED_SUB) begin : g_sub
         logic [XLEN:0] diff;
         always_comb begin
            diff    = {1'b0, a_i} - {1'b0, b_i};
            rel.eq  = (a_i == b_i);
            rel.ult = diff[XLEN];
            rel.slt = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : diff[XLEN];
         end
      end else begin : g_cmp
         always_comb begin
            rel.eq  = (a_i == b_i);
            rel.ult = (a_i < b_i);
            rel.slt = ($signed(a_i) < $signed(b_i));
         end
      end
   endgenerate

   always_comb begin
      take_o    = 1'b0;
      bad_sel_o = 1'b0;
      if (sel_i >= SEL_W'(NUM_COND)) begin
         bad_sel_o = 1'b1;
      end else begin
         case (cond_e'(sel_i[3:0]))
            CND_EQ:  take_o = rel.eq;
            CND_NE:  take_o = !rel.eq;
            CND_SLT: take_o = rel.slt;
            CND_SGT: take_o = !rel.slt && !rel.eq;
            CND_ULT: take_o = rel.ult;
            CND_UGT: take_o = !rel.ult && !rel.eq;
            CND_SGE: take_o = !rel.slt;
            CND_SLE: take_o = rel.slt || rel.eq;
            CND_UGE: take_o = !rel.ult;
            CND_ULE: take_o = rel.ult || rel.eq;
            default: bad_sel_o = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned OFFS_W = 10
) (
   input  logic [XLEN-1:0]   pc_i,
   input  logic [OFFS_W-1:0] offs_i,
   input  logic              take_i,
   input  logic              fault_i,
   output logic [XLEN-1:0]   next_pc_o
);

   localparam int unsigned EXT_W = XLEN - OFFS_W - 1;

   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] disp;

   always_comb begin
      seq_pc = pc_i + XLEN'(2);
      disp   = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i, 1'b0};
      if (fault_i)
         next_pc_o = pc_i;
      else if (take_i)
         next_pc_o = seq_pc + disp;
      else
         next_pc_o = seq_pc;
   end

endmodule

// File: rtl/cbr_resolve_unit.sv
module cbr_resolve_unit #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned OPC_W      = 16,
   parameter int unsigned OFFS_W     = 10,
   parameter int unsigned SEL_W      = 4,
   parameter bit          SHARED_SUB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_valid_i,
   input  logic [XLEN-1:0]  cmp_a_i,
   input  logic [XLEN-1:0]  cmp_b_i,
   input  logic             br_valid_i,
   input  logic [OPC_W-1:0] br_opcode_i,
   input  logic [XLEN-1:0]  br_pc_i,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             taken_o,
   output logic             illegal_o
);

   localparam int unsigned SEL_LSB = OFFS_W;
   localparam int unsigned FMT_LSB = OFFS_W + SEL_W;

   generate
      if (OPC_W != FMT_LSB + 2) begin : g_bad_opc
         $error("cbr_resolve_unit: OPC_W must equal OFFS_W + SEL_W + 2");
      end
      if (SEL_W < 4) begin : g_bad_sel
         $error("cbr_resolve_unit: SEL_W must cover ten conditions");
      end
      if (XLEN <= OFFS_W + 1) begin : g_bad_xlen
         $error("cbr_resolve_unit: XLEN too narrow for the displacement");
      end
   endgenerate

   logic [XLEN-1:0]  hold_a;
   logic [XLEN-1:0]  hold_b;
   logic [SEL_W-1:0] sel;
   logic [OFFS_W-1:0] offs;
   logic             fmt_ok;
   logic             cond_true;
   logic             bad_sel;
   logic             fault;
   logic             take;

   cbr_hold_regs #(.XLEN(XLEN)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_i  (cmp_valid_i),
      .a_i   (cmp_a_i),
      .b_i   (cmp_b_i),
      .a_q   (hold_a),
      .b_q   (hold_b)
   );

   assign sel    = br_opcode_i[SEL_LSB +: SEL_W];
   assign offs   = br_opcode_i[OFFS_W-1:0];
   assign fmt_ok = &br_opcode_i[FMT_LSB +: 2];

   cbr_cond_eval #(
      .XLEN       (XLEN),
      .SEL_W      (SEL_W),
      .SHARED_SUB (SHARED_SUB)
   ) u_eval (
      .a_i       (hold_a),
      .b_i       (hold_b),
      .sel_i     (sel),
      .take_o    (cond_true),
      .bad_sel_o (bad_sel)
   );

   assign fault = br_valid_i && (!fmt_ok || bad_sel);
   assign take  = br_valid_i && fmt_ok && !bad_sel && cond_true;

   cbr_target_gen #(
      .XLEN   (XLEN),
      .OFFS_W (OFFS_W)
   ) u_tgt (
      .pc_i      (br_pc_i),
      .offs_i    (offs),
      .take_i    (take),
      .fault_i   (fault),
      .next_pc_o (next_pc_o)
   );

   assign taken_o   = take;
   assign illegal_o = fault;

endmodule

// File: rtl/cbr_resolve_unit_chk.sv
module cbr_resolve_unit_chk #(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned OPC_W  = 16,
   parameter int unsigned OFFS_W = 10,
   parameter int unsigned SEL_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmp_valid_i,
   input logic [XLEN-1:0]  cmp_a_i,
   input logic [XLEN-1:0]  cmp_b_i,
   input logic             br_valid_i,
   input logic [OPC_W-1:0] br_opcode_i,
   input logic [XLEN-1:0]  br_pc_i,
   input logic [XLEN-1:0]  next_pc_o,
   input logic             taken_o,
   input logic             illegal_o,
   input logic [XLEN-1:0]  hold_a,
   input logic [XLEN-1:0]  hold_b
);

   // R1
   hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_valid_i |=> (hold_a == $past(cmp_a_i) && hold_b == $past(cmp_b_i)));

   // R1
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid_i |=> ($stable(hold_a) && $stable(hold_b)));

   // R7
   fault_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (next_pc_o == br_pc_i && !taken_o));

   // R6
   fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && !taken_o && !illegal_o) |-> (next_pc_o == br_pc_i + XLEN'(2)));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid_i |-> (!taken_o && !illegal_o));

   // R4
   eq_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && !illegal_o && br_opcode_i[OFFS_W +: SEL_W] == '0)
      |-> (taken_o == (hold_a == hold_b)));

endmodule

bind cbr_resolve_unit cbr_resolve_unit_chk #(
   .XLEN   (XLEN),
   .OPC_W  (OPC_W),
   .OFFS_W (OFFS_W),
   .SEL_W  (SEL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmp_valid_i (cmp_valid_i),
   .cmp_a_i     (cmp_a_i),
   .cmp_b_i     (cmp_b_i),
   .br_valid_i  (br_valid_i),
   .br_opcode_i (br_opcode_i),
   .br_pc_i     (br_pc_i),
   .next_pc_o   (next_pc_o),
   .taken_o     (taken_o),
   .illegal_o   (illegal_o),
   .hold_a      (hold_a),
   .hold_b      (hold_b)
);

// File: tb/cbr_resolve_unit_bench.sv
module cbr_resolve_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid = 1'b0;
   logic [31:0] cmp_a = '0;
   logic [31:0] cmp_b = '0;
   logic        br_valid = 1'b0;
   logic [15:0] br_opc = '0;
   logic [31:0] br_pc = '0;
   logic [31:0] npc_s, npc_d;
   logic        tk_s, tk_d, il_s, il_d;

   int checks = 0;
   int errors = 0;
   logic [31:0] ha = '0;
   logic [31:0] hb = '0;

   always #4 clk = ~clk;

   cbr_resolve_unit #(.SHARED_SUB(1'b1)) u_cbr_resolve_unit (
      .clk(clk), .rst_n(rst_n), .cmp_valid_i(cmp_valid), .cmp_a_i(cmp_a),
      .cmp_b_i(cmp_b), .br_valid_i(br_valid), .br_opcode_i(br_opc),
      .br_pc_i(br_pc), .next_pc_o(npc_s), .taken_o(tk_s), .illegal_o(il_s));

   cbr_resolve_unit #(.SHARED_SUB(1'b0)) u_cbr_resolve_unit_alt (
      .clk(clk), .rst_n(rst_n), .cmp_valid_i(cmp_valid), .cmp_a_i(cmp_a),
      .cmp_b_i(cmp_b), .br_valid_i(br_valid), .br_opcode_i(br_opc),
      .br_pc_i(br_pc), .next_pc_o(npc_d), .taken_o(tk_d), .illegal_o(il_d));

   function automatic logic model_take(input logic [3:0] s, input logic [31:0] a,
                                       input logic [31:0] b);
      case (s)
         4'd0: return a == b;
         4'd1: return a != b;
         4'd2: return $signed(a) < $signed(b);
         4'd3: return $signed(a) > $signed(b);
         4'd4: return a < b;
         4'd5: return a > b;
         4'd6: return $signed(a) >= $signed(b);
         4'd7: return $signed(a) <= $signed(b);
         4'd8: return a >= b;
         4'd9: return a <= b;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] disp(input logic [9:0] o);
      return {{21{o[9]}}, o, 1'b0};
   endfunction

   // Compare both variants (R10) against expected values.
   task automatic check(input string req, input logic [31:0] exp_pc,
                        input logic exp_tk, input logic exp_il);
      checks++;
      if (npc_s !== exp_pc || tk_s !== exp_tk || il_s !== exp_il) begin
         errors++;
         $display("FAIL %s shared: pc=%h tk=%b il=%b expected pc=%h tk=%b il=%b",
                  req, npc_s, tk_s, il_s, exp_pc, exp_tk, exp_il);
      end
      checks++;
      if (npc_d !== exp_pc || tk_d !== exp_tk || il_d !== exp_il) begin
         errors++;
         $display("FAIL %s R10 direct: pc=%h tk=%b il=%b expected pc=%h tk=%b il=%b",
                  req, npc_d, tk_d, il_d, exp_pc, exp_tk, exp_il);
      end
   endtask

   task automatic do_compare(input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_a = a; cmp_b = b;
      @(negedge clk);
      cmp_valid = 1'b0; cmp_a = ~a; cmp_b = ~b;
      ha = a; hb = b;
   endtask

   // Issue a legal branch, check against the model, then drop the request.
   task automatic do_branch(input string req, input logic [3:0] s,
                            input logic [9:0] o, input logic [31:0] pc);
      logic t;
      @(negedge clk);
      br_valid = 1'b1; br_opc = {2'b11, s, o}; br_pc = pc;
      #2;
      t = model_take(s, ha, hb);
      check(req, t ? pc + 32'd2 + disp(o) : pc + 32'd2, t, 1'b0);
      @(negedge clk);
      br_valid = 1'b0;
   endtask

   task automatic t_reset;
      #2;
      check("R9 reset idle", 32'd2, 1'b0, 1'b0);
      do_branch("R2 eq after reset", 4'd0, 10'd5, 32'h100);
      do_branch("R2 slt after reset", 4'd2, 10'd5, 32'h100);
   endtask

   task automatic t_relations;
      logic [31:0] pa [6] = '{32'd5, 32'd3, 32'd7, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000};
      logic [31:0] pb [6] = '{32'd5, 32'd7, 32'd3, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
      for (int p = 0; p < 6; p++) begin
         do_compare(pa[p], pb[p]);
         for (int s = 0; s < 10; s++)
            do_branch("R4 R1 relation", 4'(s), 10'h010, 32'h2000);
      end
   endtask

   task automatic t_offsets;
      do_compare(32'd9, 32'd9);
      do_branch("R5 max forward", 4'd0, 10'h1FF, 32'h1000);
      do_branch("R5 max backward", 4'd0, 10'h200, 32'h1000);
      do_branch("R5 minus two", 4'd0, 10'h3FF, 32'h1000);
      do_branch("R6 not taken", 4'd1, 10'h1FF, 32'h1000);
   endtask

   task automatic t_illegal;
      for (int s = 10; s < 16; s++) begin
         @(negedge clk);
         br_valid = 1'b1; br_opc = {2'b11, 4'(s), 10'h005}; br_pc = 32'h3000;
         #2 check("R7 bad selector", 32'h3000, 1'b0, 1'b1);
      end
      @(negedge clk);
      br_opc = 16'h8000;
      #2 check("R3 bit14 clear", 32'h3000, 1'b0, 1'b1);
      @(negedge clk);
      br_opc = 16'h4000;
      #2 check("R3 bit15 clear", 32'h3000, 1'b0, 1'b1);
      @(negedge clk);
      br_valid = 1'b0;
      #2 check("R9 idle after fault", 32'h3002, 1'b0, 1'b0);
   endtask

   task automatic t_same_cycle;
      do_compare(32'd4, 32'd4);
      @(negedge clk);
      cmp_valid = 1'b1; cmp_a = 32'd1; cmp_b = 32'd2;
      br_valid = 1'b1; br_opc = {2'b11, 4'd0, 10'd8}; br_pc = 32'h400;
      #2 check("R8 old operands used", 32'h400 + 32'd2 + 32'd16, 1'b1, 1'b0);
      @(negedge clk);
      cmp_valid = 1'b0; cmp_a = 32'd77; cmp_b = 32'd0;
      #2 check("R8 new operands next", 32'h402, 1'b0, 1'b0);
      @(negedge clk);
      br_valid = 1'b0;
      ha = 32'd1; hb = 32'd2;
   endtask

   task automatic t_hold;
      @(negedge clk);
      cmp_a = 32'd2; cmp_b = 32'd2;
      @(negedge clk);
      do_branch("R1 ignore without strobe", 4'd4, 10'd3, 32'h500);
   endtask

   initial begin
      #200_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_relations();
      t_offsets();
      t_illegal();
      t_same_cycle();
      t_hold();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule